// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block decides which analog input a successive-approximation converter samples next. With scanning on, one trigger walks the converter through a contiguous window of channels, from a programmed first index up to a programmed last index. In single mode it makes one pass and then reports the sweep as finished. In continuous mode it wraps back to the first index and keeps going for as long as continuous mode stays selected. With scanning off it converts one fixed channel, which is the first index.

Every conversion uses the same settings. The sequencer holds no per-channel state. Finished samples leave through a one-entry valid/ready output stage, and that stage carries only the sample word, with no channel number attached. The stage applies back-pressure: while it holds an unread sample, no new conversion is started. A decimation request is passed through only while scanning is off.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset `conv_start`, `sweep_done` and `res_valid` are 0 and the sequencer is idle.
- R2: A `trig` seen while idle produces a one-cycle `conv_start` in the next cycle, provided the output stage is empty. Each conversion gets exactly one `conv_start`. The next `conv_start` comes only after `conv_done` for the current conversion.
- R3: With `scan_en`=1 and `ch_start` <= `ch_end`, successive conversions select `ch_start`, `ch_start`+1, … up to `ch_end`, in that order. `ch_sel` holds its value through each conversion.
- R4: With `cont_mode`=1, the conversion after `ch_end` selects `ch_start` again. Once `cont_mode` is 0, the sequencer goes idle at the end of the current pass.
- R5: In single mode with scanning on, `conv_done` for the last channel leads to a one-cycle `sweep_done` in the following cycle, and the sequencer returns to idle.
- R6: If `ch_start` > `ch_end`, a pass converts only `ch_start`.
- R7: With `scan_en`=0, `ch_sel` equals `ch_start` and `sweep_done` never rises. A single-mode trigger gives one conversion, and continuous mode repeats that same channel.
- R8: `res_data` equals `conv_data` as captured at `conv_done`. `res_valid` stays 1 and `res_data` stays stable until `res_ready` is 1. No `conv_start` is issued while `res_valid` is 1.
- R9: `deci_active` equals `deci_req` AND NOT `scan_en`.
- R10: `trig` has no effect while a pass is in progress. `conv_done` has no effect while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_en | input | 1 | 1 = sweep the channel window |
| cont_mode | input | 1 | 1 = continuous, 0 = single pass |
| ch_start | input | CH_W | First channel of the window (the fixed channel when not scanning) |
| ch_end | input | CH_W | Last channel of the window |
| trig | input | 1 | Starts a pass when idle |
| deci_req | input | 1 | Decimation request |
| conv_done | input | 1 | Converter finished the current sample |
| conv_data | input | DATA_W | Sample word from the converter |
| ch_sel | output | CH_W | Channel select to the converter |
| conv_start | output | 1 | One-cycle start-conversion pulse |
| sweep_done | output | 1 | One-cycle end-of-sweep pulse (single mode) |
| deci_active | output | 1 | Decimation actually enabled |
| res_valid | output | 1 | Output sample available |
| res_ready | input | 1 | Consumer accepts the output sample |
| res_data | output | DATA_W | Output sample, no channel tag |

## Verification
The bench uses the default parameters: 4-bit channel indices and 16-bit samples. Because the indices are 4 bits wide, the top channel 15 can be reached directly. This covers a window that ends exactly at the index limit, a single-channel window at 15, and a reversed window. With 16-bit samples, the behavioural converter stub can place the selected channel in the low bits of each sample. The consumer side sees results in order, so the sweep order can be recovered there even though the block attaches no tag. Randomised `res_ready` during continuous mode exercises back-pressure against the wrap from channel 15 to 14.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_BUSY  = 2'd2
  } sq_state_t;
endpackage

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scan_en,
  input  logic            cont_mode,
  input  logic [CH_W-1:0] ch_start,
  input  logic [CH_W-1:0] ch_end,
  input  logic            trig,
  input  logic            conv_done,
  input  logic            slot_full,
  output logic [CH_W-1:0] ch_sel,
  output logic            conv_start,
  output logic            sweep_done,
  output logic            capture
);

  sq_state_t       state_q, state_d;
  logic [CH_W-1:0] cur_q, cur_d;
  logic            sweep_d;
  logic            at_last;

  // last conversion of a pass: fixed-channel mode, or window end reached
  // (a reversed window also lands here after its first channel)
  assign at_last    = !scan_en || (cur_q >= ch_end);
  assign conv_start = (state_q == SQ_ISSUE) && !slot_full;
  assign capture    = (state_q == SQ_BUSY) && conv_done;
  assign ch_sel     = ((state_q == SQ_IDLE) || !scan_en) ? ch_start : cur_q;

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    sweep_d = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (trig) begin
          state_d = SQ_ISSUE;
          cur_d   = ch_start;
        end
      end
      SQ_ISSUE: begin
        if (!slot_full) state_d = SQ_BUSY;
      end
      SQ_BUSY: begin
        if (conv_done) begin
          if (!at_last) begin
            cur_d   = cur_q + 1'b1;
            state_d = SQ_ISSUE;
          end else if (cont_mode) begin
            cur_d   = ch_start;
            state_d = SQ_ISSUE;
          end else begin
            state_d = SQ_IDLE;
            sweep_d = scan_en;
          end
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SQ_IDLE;
      cur_q      <= '0;
      sweep_done <= 1'b0;
    end else begin
      state_q    <= state_d;
      cur_q      <= cur_d;
      sweep_done <= sweep_d;
    end
  end

  a_r2_start_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  a_r2_no_start_while_converting: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_BUSY && !conv_done) |=> !conv_start);

  a_r5_sweep_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |=> !sweep_done);

  a_r7_no_sweep_unscanned: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> !sweep_done);

  a_r3_hold_channel: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_BUSY && !conv_done && $stable(scan_en) && $stable(ch_start))
      |=> $stable(ch_sel));

endmodule

// File: rtl/adc_scan_slot.sv
module adc_scan_slot #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else if (load) begin
      res_valid <= 1'b1;
      res_data  <= din;
    end else if (res_valid && res_ready) begin
      res_valid <= 1'b0;
    end
  end

  a_r8_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

endmodule

// File: rtl/adc_scan_deci_gate.sv
module adc_scan_deci_gate (
  input  logic scan_en,
  input  logic deci_req,
  output logic deci_active
);

  assign deci_active = deci_req & ~scan_en;

  always_comb begin
    a_r9_no_deci_in_scan: assert (!(deci_active && scan_en));
  end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int CH_W   = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_en,
  input  logic              cont_mode,
  input  logic [CH_W-1:0]   ch_start,
  input  logic [CH_W-1:0]   ch_end,
  input  logic              trig,
  input  logic              deci_req,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic [CH_W-1:0]   ch_sel,
  output logic              conv_start,
  output logic              sweep_done,
  output logic              deci_active,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data
);

  logic capture;

  adc_scan_ctrl #(.CH_W(CH_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_en    (scan_en),
    .cont_mode  (cont_mode),
    .ch_start   (ch_start),
    .ch_end     (ch_end),
    .trig       (trig),
    .conv_done  (conv_done),
    .slot_full  (res_valid),
    .ch_sel     (ch_sel),
    .conv_start (conv_start),
    .sweep_done (sweep_done),
    .capture    (capture)
  );

  adc_scan_slot #(.DATA_W(DATA_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (capture),
    .din       (conv_data),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_data  (res_data)
  );

  adc_scan_deci_gate u_deci (
    .scan_en     (scan_en),
    .deci_req    (deci_req),
    .deci_active (deci_active)
  );

  a_r8_no_start_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !conv_start);

endmodule

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;
  localparam int CH_W   = 4;
  localparam int DATA_W = 16;
  localparam int LAT    = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              scan_en = 1'b0, cont_mode = 1'b0, trig = 1'b0, deci_req = 1'b0;
  logic [CH_W-1:0]   ch_start = '0, ch_end = '0;
  logic              conv_done;
  logic [DATA_W-1:0] conv_data;
  logic [CH_W-1:0]   ch_sel;
  logic              conv_start, sweep_done, deci_active, res_valid;
  logic              res_ready = 1'b1;
  logic [DATA_W-1:0] res_data;
  logic              extra_done = 1'b0;
  logic              rand_ready = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  adc_scan_seq #(.CH_W(CH_W), .DATA_W(DATA_W)) u_adc_scan_seq (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .cont_mode(cont_mode),
    .ch_start(ch_start), .ch_end(ch_end), .trig(trig), .deci_req(deci_req),
    .conv_done(conv_done), .conv_data(conv_data), .ch_sel(ch_sel),
    .conv_start(conv_start), .sweep_done(sweep_done), .deci_active(deci_active),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
  );

  // behavioural converter stub: sample word = {8'hC3, seq, channel}
  int              stub_cnt = 0;
  logic [3:0]      stub_seq = '0;
  logic [CH_W-1:0] stub_ch = '0;
  always @(posedge clk) begin
    if (conv_start) begin
      stub_cnt <= LAT;
      stub_ch  <= ch_sel;
      stub_seq <= stub_seq + 4'd1;
    end else if (stub_cnt > 0) begin
      stub_cnt <= stub_cnt - 1;
    end
  end
  assign conv_done = (stub_cnt == 1) || extra_done;
  assign conv_data = {8'hC3, stub_seq, stub_ch};

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model: 0 idle, 1 issuing, 2 converting
  int         m_st = 0;
  int         m_cur = 0;
  bit         m_sweep = 0;
  bit         m_valid = 0;
  logic [DATA_W-1:0] m_data = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cur = 0; m_sweep = 0; m_valid = 0; m_data = '0;
    end else begin
      automatic bit fire  = (m_st == 1) && !m_valid;
      automatic bit cap   = (m_st == 2) && conv_done;
      automatic bit last  = !scan_en || (m_cur >= int'(ch_end));
      automatic bit pop   = m_valid && res_ready;
      m_sweep = 0;
      if (cap) begin
        m_valid = 1; m_data = conv_data;
      end else if (pop) begin
        m_valid = 0;
      end
      case (m_st)
        0: if (trig) begin m_st = 1; m_cur = int'(ch_start); end
        1: if (fire) m_st = 2;
        default: if (cap) begin
          if (!last) begin m_cur = m_cur + 1; m_st = 1; end
          else if (cont_mode) begin m_cur = int'(ch_start); m_st = 1; end
          else begin m_st = 0; m_sweep = scan_en; end
        end
      endcase
    end
  end

  // results seen by the consumer, channel in low nibble
  int res_q[$];
  int sweeps = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      automatic int exp_ch = (m_st == 0 || !scan_en) ? int'(ch_start) : m_cur;
      chk("R3", "ch_sel", 32'(ch_sel), 32'(exp_ch));
      chk("R2", "conv_start", 32'(conv_start), 32'((m_st == 1) && !m_valid));
      chk("R5", "sweep_done", 32'(sweep_done), 32'(m_sweep));
      chk("R8", "res_valid", 32'(res_valid), 32'(m_valid));
      if (m_valid) chk("R8", "res_data", 32'(res_data), 32'(m_data));
      chk("R9", "deci_active", 32'(deci_active), 32'(deci_req && !scan_en));
      if (res_valid && res_ready) res_q.push_back(int'(res_data[3:0]));
      if (sweep_done) sweeps++;
    end
  end

  always @(posedge clk) if (rand_ready) #2 res_ready = 1'($urandom_range(0, 1));

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic pulse_trig();
    trig = 1'b1; step(1); trig = 1'b0;
  endtask

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd == 100000 && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<100000", wd);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    #5;
    // R1 reset state
    chk("R1", "conv_start", 32'(conv_start), 0);
    chk("R1", "sweep_done", 32'(sweep_done), 0);
    chk("R1", "res_valid", 32'(res_valid), 0);
    step(1);

    // R3/R5: single scan 2..5, plus an ignored trig mid-pass (R10)
    scan_en = 1; cont_mode = 0; ch_start = 2; ch_end = 5;
    res_q.delete(); sweeps = 0;
    pulse_trig();
    step(6);
    pulse_trig();
    step(50);
    chk("R3", "scan count", 32'(res_q.size()), 4);
    for (int i = 0; i < 4 && i < res_q.size(); i++)
      chk("R3", "scan order", 32'(res_q[i]), 32'(2 + i));
    chk("R5", "sweep pulses", 32'(sweeps), 1);
    chk("R10", "trig during pass ignored", 32'(res_q.size()), 4);

    // R6: reversed window
    ch_start = 7; ch_end = 3; res_q.delete(); sweeps = 0;
    pulse_trig(); step(30);
    chk("R6", "reversed count", 32'(res_q.size()), 1);
    if (res_q.size() > 0) chk("R6", "reversed channel", 32'(res_q[0]), 7);
    chk("R6", "reversed sweep", 32'(sweeps), 1);

    // boundary: single-channel window at top index
    ch_start = 15; ch_end = 15; res_q.delete(); sweeps = 0;
    pulse_trig(); step(30);
    chk("R3", "top window count", 32'(res_q.size()), 1);
    if (res_q.size() > 0) chk("R3", "top window channel", 32'(res_q[0]), 15);

    // R7: scanning off, fixed channel, no sweep pulse; R9 decimation passes
    scan_en = 0; ch_start = 9; ch_end = 12; deci_req = 1; res_q.delete(); sweeps = 0;
    step(1);
    chk("R9", "deci when not scanning", 32'(deci_active), 1);
    chk("R7", "fixed ch_sel", 32'(ch_sel), 9);
    pulse_trig(); step(30);
    chk("R7", "fixed count", 32'(res_q.size()), 1);
    if (res_q.size() > 0) chk("R7", "fixed channel", 32'(res_q[0]), 9);
    chk("R7", "no sweep pulse", 32'(sweeps), 0);
    scan_en = 1; step(1);
    chk("R9", "deci blocked while scanning", 32'(deci_active), 0);
    deci_req = 0;

    // R10: conv_done while idle is ignored
    extra_done = 1; step(1); extra_done = 0; step(2);
    chk("R10", "stray done no result", 32'(res_valid), 0);

    // R4/R8: continuous 14..15 with random back-pressure
    ch_start = 14; ch_end = 15; cont_mode = 1; res_q.delete(); sweeps = 0;
    rand_ready = 1;
    pulse_trig(); step(120);
    cont_mode = 0; step(60);
    rand_ready = 0; res_ready = 1; step(10);
    chk("R4", "enough wraps", 32'(res_q.size() >= 6), 1);
    chk("R4", "ends on pass boundary", 32'(res_q.size() % 2), 0);
    for (int i = 0; i < res_q.size(); i++)
      chk("R4", "wrap order", 32'(res_q[i]), 32'((i % 2 == 0) ? 14 : 15));
    chk("R5", "single sweep after cont", 32'(sweeps), 1);

    // R7: continuous with scanning off repeats the start channel
    scan_en = 0; cont_mode = 1; ch_start = 4; res_q.delete(); sweeps = 0;
    pulse_trig(); step(40);
    cont_mode = 0; step(20);
    chk("R7", "cont fixed repeats", 32'(res_q.size() >= 3), 1);
    for (int i = 0; i < res_q.size(); i++)
      chk("R7", "cont fixed channel", 32'(res_q[i]), 4);
    chk("R7", "cont fixed no sweep", 32'(sweeps), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule